// File: doc/BRIEF.md
# Single-Channel Memory Copy Engine

This block is one channel of a memory-to-memory copy engine. Software sets up a source address, a destination address, a unit count and a handful of mode bits, then pulses `start`. The channel walks both addresses, moving one unit per step. Each step is a bus read followed by a bus write of the captured data. After each step, both addresses move by a signed stride that depends on the unit width and on a per-side adjust mode.

Each side's stride is worked out once, when the start is accepted, and is then reused for every unit. The bus sees aligned addresses, while the channel's own address registers keep any low bits that were programmed. Only the first access of a block is marked non-sequential; every access after it is marked sequential. A burst mode ignores the programmed count and the width bit and moves four 32-bit words. When the block finishes, an optional interrupt pulse is raised. A reserved source adjust code stops the block before any bus access and sets a sticky error flag.

Top module: `dma_xfer_engine`

## Requirements
- R1: The unit is 4 bytes when `cfg_wide` is 1 and 2 bytes when it is 0. Every access in a block drives `bus_wide` equal to the effective width (1 means 32-bit).
- R2: Source adjust codes on `cfg_src_mode` have these meanings: 0 adds one unit after each unit moved, 1 subtracts one unit, and 2 keeps the address fixed.
- R3: Destination adjust codes on `cfg_dst_mode` have these meanings: 0 and 3 both add one unit, 1 subtracts one unit, and 2 keeps the address fixed.
- R4: The bus address has bits [1:0] cleared for 32-bit accesses and bit 0 cleared for 16-bit accesses. Stepping continues from the unaligned internal value.
- R5: The first read of a block has `bus_seq`=0. Every later access in the same block, including the first write, has `bus_seq`=1.
- R6: With `cfg_fifo`=1 the channel moves exactly four 32-bit units, whatever `cfg_count` and `cfg_wide` are.
- R7: With `cfg_fifo`=0 the channel moves `cfg_count` units. A count of 0 makes no bus access.
- R8: Each unit is a read (`bus_we`=0) and then a write (`bus_we`=1). The write's `bus_wdata` equals the `bus_rdata` returned for that read. A request holds steady until `bus_ready` is seen.
- R9: `busy` is 1 from the cycle after an accepted start until the cycle after the last write is accepted.
- R10: On completion `irq` is high for exactly one cycle if `cfg_irq_en` was 1 at start, and stays low otherwise. This includes a count of 0.
- R11: Source code 3 sets `err`, which stays set until reset. No bus access follows, `busy` stays 0 and `irq` stays low.
- R12: Address stepping wraps modulo 2^32 in both directions.
- R13: A `start` pulse while `busy` is 1 is ignored and leaves the running block unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| start | input | 1 | Start pulse, sampled when idle |
| cfg_wide | input | 1 | 1: 32-bit units, 0: 16-bit units |
| cfg_fifo | input | 1 | Burst mode: four 32-bit units |
| cfg_irq_en | input | 1 | Raise irq on completion |
| cfg_src_mode | input | 2 | Source adjust code |
| cfg_dst_mode | input | 2 | Destination adjust code |
| cfg_src_addr | input | 32 | Source start address |
| cfg_dst_addr | input | 32 | Destination start address |
| cfg_count | input | 16 | Units to move outside burst mode |
| bus_req | output | 1 | Access request |
| bus_we | output | 1 | 1: write, 0: read |
| bus_wide | output | 1 | 1: 32-bit access, 0: 16-bit access |
| bus_seq | output | 1 | 1: sequential, 0: non-sequential |
| bus_addr | output | 32 | Aligned access address |
| bus_wdata | output | 32 | Write data |
| bus_ready | input | 1 | Access accepted this cycle |
| bus_rdata | input | 32 | Read data, valid with bus_ready on a read |
| busy | output | 1 | Block in progress |
| irq | output | 1 | One-cycle completion pulse |
| err | output | 1 | Sticky illegal source code flag |

## Verification
The bench covers the adjust-mode pairs up, down, fixed and destination code 3, in both widths. It uses odd and half-aligned start addresses, which separate bus alignment from internal stepping. Wrap is exercised from the top and the bottom of the address space. A burst run with a large count and the width bit cleared shows that the burst overrides both fields. A zero count, an illegal source code and a restart pulse during a block each test a path that must make no access. A varying ready delay shows that requests hold steady and that only the first read is non-sequential.

// File: rtl/dma_eng_pkg.sv
`timescale 1ns/1ps
package dma_eng_pkg;

    localparam int ADDR_W     = 32;
    localparam int DATA_W     = 32;
    localparam int CNT_W      = 16;
    localparam int FIFO_WORDS = 4;

    typedef logic [ADDR_W-1:0] addr_t;
    typedef logic [DATA_W-1:0] data_t;
    typedef logic [CNT_W-1:0]  cnt_t;

    typedef enum logic [1:0] {
        ADJ_UP   = 2'd0,
        ADJ_DOWN = 2'd1,
        ADJ_HOLD = 2'd2,
        ADJ_ALT  = 2'd3
    } adj_mode_t;

    typedef enum logic [1:0] {
        ENG_IDLE  = 2'd0,
        ENG_READ  = 2'd1,
        ENG_WRITE = 2'd2
    } eng_state_t;

    typedef struct packed {
        logic src_bad;
        addr_t src_step;
        addr_t dst_step;
    } step_pair_t;

    function automatic addr_t unit_bytes(input logic wide);
        return wide ? addr_t'(4) : addr_t'(2);
    endfunction

    function automatic addr_t align_addr(input addr_t a, input logic wide);
        return wide ? {a[ADDR_W-1:2], 2'b00} : {a[ADDR_W-1:1], 1'b0};
    endfunction

    // Signed stride as a two's-complement value; code 3 means increment on
    // the destination side and is reserved on the source side.
    function automatic addr_t stride_of(input adj_mode_t m, input logic wide,
                                        input logic is_dst);
        addr_t u;
        u = unit_bytes(wide);
        case (m)
            ADJ_UP:   return u;
            ADJ_DOWN: return addr_t'(0) - u;
            ADJ_HOLD: return addr_t'(0);
            default:  return is_dst ? u : addr_t'(0);
        endcase
    endfunction

endpackage

// File: rtl/dma_step_decode.sv
`timescale 1ns/1ps
module dma_step_decode
    import dma_eng_pkg::*;
(
    input  logic       wide_eff,
    input  logic [1:0] src_mode,
    input  logic [1:0] dst_mode,
    output step_pair_t steps
);

    always_comb begin
        steps.src_bad  = (adj_mode_t'(src_mode) == ADJ_ALT);
        steps.src_step = stride_of(adj_mode_t'(src_mode), wide_eff, 1'b0);
        steps.dst_step = stride_of(adj_mode_t'(dst_mode), wide_eff, 1'b1);
    end

endmodule

// File: rtl/dma_addr_unit.sv
`timescale 1ns/1ps
module dma_addr_unit
    import dma_eng_pkg::*;
(
    input  logic       clk,
    input  logic       rst,
    input  logic       load,
    input  logic       advance,
    input  logic       wide_in,
    input  addr_t      src_base,
    input  addr_t      dst_base,
    input  step_pair_t steps,
    output logic       wide_q,
    output addr_t      src_bus,
    output addr_t      dst_bus
);

    addr_t src_q, dst_q;
    addr_t src_step_q, dst_step_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            src_q      <= '0;
            dst_q      <= '0;
            src_step_q <= '0;
            dst_step_q <= '0;
            wide_q     <= 1'b0;
        end else if (load) begin
            src_q      <= src_base;
            dst_q      <= dst_base;
            src_step_q <= steps.src_step;
            dst_step_q <= steps.dst_step;
            wide_q     <= wide_in;
        end else if (advance) begin
            src_q <= src_q + src_step_q;
            dst_q <= dst_q + dst_step_q;
        end
    end

    assign src_bus = align_addr(src_q, wide_q);
    assign dst_bus = align_addr(dst_q, wide_q);

    AST_ADDR_HOLD: assert property (@(posedge clk) disable iff (rst)
        (!load && !advance) |=> ($stable(src_q) && $stable(dst_q))); // R4

    AST_STRIDE_KEPT: assert property (@(posedge clk) disable iff (rst)
        !load |=> ($stable(src_step_q) && $stable(dst_step_q))); // R2

endmodule

// File: rtl/dma_seq_ctrl.sv
`timescale 1ns/1ps
module dma_seq_ctrl
    import dma_eng_pkg::*;
(
    input  logic  clk,
    input  logic  rst,
    input  logic  start,
    input  logic  src_bad,
    input  logic  cfg_fifo,
    input  logic  cfg_irq_en,
    input  cnt_t  cfg_count,
    input  logic  bus_ready,
    input  data_t bus_rdata,
    output logic  load,
    output logic  advance,
    output logic  bus_req,
    output logic  bus_we,
    output logic  bus_seq,
    output data_t bus_wdata,
    output logic  busy,
    output logic  irq,
    output logic  err
);

    eng_state_t state;
    cnt_t       remain;
    logic       first;
    logic       irq_en_q;
    data_t      hold;
    logic       accept;
    cnt_t       units;

    assign accept  = start && (state == ENG_IDLE);
    assign units   = cfg_fifo ? cnt_t'(FIFO_WORDS) : cfg_count;
    assign load    = accept && !src_bad && (units != '0);
    assign advance = (state == ENG_WRITE) && bus_ready;

    always_ff @(posedge clk) begin
        if (rst) begin
            state    <= ENG_IDLE;
            remain   <= '0;
            first    <= 1'b0;
            irq_en_q <= 1'b0;
            hold     <= '0;
            irq      <= 1'b0;
            err      <= 1'b0;
        end else begin
            irq <= 1'b0;
            case (state)
                ENG_IDLE: begin
                    if (accept) begin
                        if (src_bad) begin
                            err <= 1'b1;
                        end else if (units == '0) begin
                            irq <= cfg_irq_en;
                        end else begin
                            remain   <= units;
                            first    <= 1'b1;
                            irq_en_q <= cfg_irq_en;
                            state    <= ENG_READ;
                        end
                    end
                end
                ENG_READ: begin
                    if (bus_ready) begin
                        hold  <= bus_rdata;
                        first <= 1'b0;
                        state <= ENG_WRITE;
                    end
                end
                ENG_WRITE: begin
                    if (bus_ready) begin
                        remain <= remain - cnt_t'(1);
                        if (remain == cnt_t'(1)) begin
                            state <= ENG_IDLE;
                            irq   <= irq_en_q;
                        end else begin
                            state <= ENG_READ;
                        end
                    end
                end
                default: state <= ENG_IDLE;
            endcase
        end
    end

    assign bus_req   = (state == ENG_READ) || (state == ENG_WRITE);
    assign bus_we    = (state == ENG_WRITE);
    assign bus_seq   = !((state == ENG_READ) && first);
    assign bus_wdata = hold;
    assign busy      = (state != ENG_IDLE);

    AST_ERR_STICKY: assert property (@(posedge clk) disable iff (rst)
        err |=> err); // R11

    AST_IRQ_ONE_CYCLE: assert property (@(posedge clk) disable iff (rst)
        irq |=> !irq); // R10

    AST_REQ_HELD: assert property (@(posedge clk) disable iff (rst)
        (bus_req && !bus_ready) |=> (bus_req && $stable(bus_we))); // R8

    AST_READ_THEN_WRITE: assert property (@(posedge clk) disable iff (rst)
        (bus_req && !bus_we && bus_ready) |=> (bus_req && bus_we)); // R8

    AST_NONSEQ_ONLY_READ: assert property (@(posedge clk) disable iff (rst)
        (bus_req && !bus_seq) |-> !bus_we); // R5

    AST_REMAIN_LIVE: assert property (@(posedge clk) disable iff (rst)
        busy |-> (remain != '0)); // R7

endmodule

// File: rtl/dma_xfer_engine.sv
`timescale 1ns/1ps
module dma_xfer_engine
    import dma_eng_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              start,
    input  logic              cfg_wide,
    input  logic              cfg_fifo,
    input  logic              cfg_irq_en,
    input  logic [1:0]        cfg_src_mode,
    input  logic [1:0]        cfg_dst_mode,
    input  logic [ADDR_W-1:0] cfg_src_addr,
    input  logic [ADDR_W-1:0] cfg_dst_addr,
    input  logic [CNT_W-1:0]  cfg_count,
    output logic              bus_req,
    output logic              bus_we,
    output logic              bus_wide,
    output logic              bus_seq,
    output logic [ADDR_W-1:0] bus_addr,
    output logic [DATA_W-1:0] bus_wdata,
    input  logic              bus_ready,
    input  logic [DATA_W-1:0] bus_rdata,
    output logic              busy,
    output logic              irq,
    output logic              err
);

    logic       wide_eff;
    step_pair_t steps;
    logic       load, advance;
    addr_t      src_bus, dst_bus;

    assign wide_eff = cfg_wide | cfg_fifo;

    dma_step_decode u_decode (
        .wide_eff (wide_eff),
        .src_mode (cfg_src_mode),
        .dst_mode (cfg_dst_mode),
        .steps    (steps)
    );

    dma_addr_unit u_addr (
        .clk      (clk),
        .rst      (rst),
        .load     (load),
        .advance  (advance),
        .wide_in  (wide_eff),
        .src_base (cfg_src_addr),
        .dst_base (cfg_dst_addr),
        .steps    (steps),
        .wide_q   (bus_wide),
        .src_bus  (src_bus),
        .dst_bus  (dst_bus)
    );

    dma_seq_ctrl u_ctrl (
        .clk        (clk),
        .rst        (rst),
        .start      (start),
        .src_bad    (steps.src_bad),
        .cfg_fifo   (cfg_fifo),
        .cfg_irq_en (cfg_irq_en),
        .cfg_count  (cfg_count),
        .bus_ready  (bus_ready),
        .bus_rdata  (bus_rdata),
        .load       (load),
        .advance    (advance),
        .bus_req    (bus_req),
        .bus_we     (bus_we),
        .bus_seq    (bus_seq),
        .bus_wdata  (bus_wdata),
        .busy       (busy),
        .irq        (irq),
        .err        (err)
    );

    assign bus_addr = bus_we ? dst_bus : src_bus;

    AST_BUS_ALIGNED: assert property (@(posedge clk) disable iff (rst)
        bus_req |-> (bus_wide ? (bus_addr[1:0] == 2'b00) : (bus_addr[0] == 1'b0))); // R4

    AST_ADDR_HELD: assert property (@(posedge clk) disable iff (rst)
        (bus_req && !bus_ready) |=> $stable(bus_addr)); // R8

    AST_REQ_NEEDS_BUSY: assert property (@(posedge clk) disable iff (rst)
        bus_req |-> busy); // R9

endmodule

// File: tb/tb_dma_xfer_engine.sv
`timescale 1ns/1ps
module tb_dma_xfer_engine;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        start = 1'b0;
    logic        cfg_wide = 1'b0, cfg_fifo = 1'b0, cfg_irq_en = 1'b0;
    logic [1:0]  cfg_src_mode = 2'd0, cfg_dst_mode = 2'd0;
    logic [31:0] cfg_src_addr = '0, cfg_dst_addr = '0;
    logic [15:0] cfg_count = '0;
    logic        bus_req, bus_we, bus_wide, bus_seq;
    logic [31:0] bus_addr, bus_wdata;
    logic        bus_ready = 1'b0;
    logic [31:0] bus_rdata = '0;
    logic        busy, irq, err;

    always #4 clk = ~clk;

    dma_xfer_engine dut (
        .clk(clk), .rst(rst), .start(start),
        .cfg_wide(cfg_wide), .cfg_fifo(cfg_fifo), .cfg_irq_en(cfg_irq_en),
        .cfg_src_mode(cfg_src_mode), .cfg_dst_mode(cfg_dst_mode),
        .cfg_src_addr(cfg_src_addr), .cfg_dst_addr(cfg_dst_addr),
        .cfg_count(cfg_count),
        .bus_req(bus_req), .bus_we(bus_we), .bus_wide(bus_wide),
        .bus_seq(bus_seq), .bus_addr(bus_addr), .bus_wdata(bus_wdata),
        .bus_ready(bus_ready), .bus_rdata(bus_rdata),
        .busy(busy), .irq(irq), .err(err)
    );

    typedef struct {
        bit          we;
        logic [31:0] addr;
        bit          seq;
        bit          wide;
        logic [31:0] data;
        bit          last;
    } xact_t;

    xact_t expq[$];
    int    checks = 0, errors = 0, cycles = 0;
    bit    mon_on = 0, hs_pending = 0;
    bit    model_busy = 0, model_err = 0, exp_irq = 0, cur_irq = 0;
    int    wait_cnt = 0;
    logic [7:0] lfsr = 8'h5B;

    function automatic logic [31:0] memf(input logic [31:0] a);
        return (a * 32'h9E37_79B1) ^ 32'h5A5A_0F0F;
    endfunction

    task automatic chk(input bit ok, input string tag, input logic [31:0] act,
                       input logic [31:0] exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s: actual %h expected %h", tag, act, exp);
        end
    endtask

    task automatic report;
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    endtask

    // Reference monitor and bus responder, on the falling edge.
    always @(negedge clk) begin
        if (mon_on) begin
            xact_t it;
            cycles++;
            if (cycles > 100000) begin
                errors++;
                $display("FAIL watchdog: actual %0d expected below 100000", cycles);
                report();
            end
            if (hs_pending) begin
                hs_pending = 0;
                it = expq.pop_front();
                if (it.last) begin
                    model_busy = 0;
                    exp_irq = cur_irq;
                end
            end
            chk(busy == model_busy, "R9 busy", 32'(busy), 32'(model_busy));
            chk(irq == exp_irq, "R10 irq", 32'(irq), 32'(exp_irq));
            exp_irq = 0;
            chk(err == model_err, "R11 err", 32'(err), 32'(model_err));
            bus_ready = 1'b0;
            if (bus_req) begin
                if (expq.size() == 0) begin
                    chk(1'b0, "R7 unexpected access", bus_addr, 32'hFFFF_FFFF);
                end else begin
                    it = expq[0];
                    chk(bus_we == it.we, "R8 direction", 32'(bus_we), 32'(it.we));
                    chk(bus_addr == it.addr, "R4 address", bus_addr, it.addr);
                    chk(bus_seq == it.seq, "R5 seq tag", 32'(bus_seq), 32'(it.seq));
                    chk(bus_wide == it.wide, "R1 width", 32'(bus_wide), 32'(it.wide));
                    if (it.we)
                        chk(bus_wdata == it.data, "R8 write data", bus_wdata, it.data);
                end
                if (wait_cnt == 0) begin
                    bus_ready = 1'b1;
                    if (!bus_we) bus_rdata = memf(bus_addr);
                    hs_pending = (expq.size() != 0);
                    wait_cnt = int'(lfsr % 3);
                    lfsr = {lfsr[6:0], lfsr[7] ^ lfsr[5] ^ lfsr[4] ^ lfsr[3]};
                end else begin
                    wait_cnt--;
                end
            end
        end
    end

    task automatic run_job(input bit wide, input bit fifo, input bit ien,
                           input logic [1:0] sm, input logic [1:0] dm,
                           input logic [31:0] src, input logic [31:0] dst,
                           input logic [15:0] cnt, input bit wait_done);
        bit was_busy;
        @(posedge clk); #2;
        cfg_wide = wide; cfg_fifo = fifo; cfg_irq_en = ien;
        cfg_src_mode = sm; cfg_dst_mode = dm;
        cfg_src_addr = src; cfg_dst_addr = dst; cfg_count = cnt;
        start = 1'b1;
        was_busy = model_busy;
        @(posedge clk); #2;
        start = 1'b0;
        if (!was_busy) begin
            if (sm == 2'd3) begin
                model_err = 1;
            end else begin
                int units;
                bit w;
                logic [31:0] u, ss, ds, s, d, sa;
                units = fifo ? 4 : int'(cnt);
                w = wide | fifo;
                u = w ? 32'd4 : 32'd2;
                ss = (sm == 2'd0) ? u : (sm == 2'd1) ? (32'd0 - u) : 32'd0;
                ds = (dm == 2'd1) ? (32'd0 - u) : (dm == 2'd2) ? 32'd0 : u;
                s = src; d = dst;
                for (int k = 0; k < units; k++) begin
                    xact_t r, wr;
                    sa = w ? (s & ~32'd3) : (s & ~32'd1);
                    r.we = 0; r.addr = sa; r.seq = (k > 0); r.wide = w;
                    r.data = '0; r.last = 0;
                    wr.we = 1; wr.addr = w ? (d & ~32'd3) : (d & ~32'd1);
                    wr.seq = 1; wr.wide = w; wr.data = memf(sa);
                    wr.last = (k == units - 1);
                    expq.push_back(r);
                    expq.push_back(wr);
                    s = s + ss; d = d + ds;
                end
                cur_irq = ien;
                if (units == 0) exp_irq = ien;
                else model_busy = 1;
            end
        end
        if (wait_done) begin
            while (model_busy || expq.size() != 0) @(negedge clk);
            repeat (3) @(negedge clk);
            chk(expq.size() == 0, "R7 all units moved", 32'(expq.size()), 32'd0);
        end
    endtask

    initial begin
        repeat (4) @(posedge clk);
        #2 rst = 1'b0;
        mon_on = 1;
        @(negedge clk);
        chk(bus_req == 1'b0, "R9 reset no request", 32'(bus_req), 32'd0);
        chk(busy == 1'b0, "R9 reset idle", 32'(busy), 32'd0);
        // R1 R2 R3 R5 R10: 16-bit, both up, odd source
        run_job(0, 0, 1, 2'd0, 2'd0, 32'h0000_1001, 32'h0000_2000, 16'd3, 1);
        // R2 R3 R4: 32-bit, source down, destination fixed, half-aligned
        run_job(1, 0, 0, 2'd1, 2'd2, 32'h0000_3006, 32'h0000_4002, 16'd5, 1);
        // R3: source fixed, destination code 3 increments
        run_job(1, 0, 1, 2'd2, 2'd3, 32'h0000_5000, 32'h0000_6003, 16'd2, 1);
        // R3: 16-bit destination down
        run_job(0, 0, 1, 2'd0, 2'd1, 32'h0000_7000, 32'h0000_8007, 16'd4, 1);
        // R6: burst overrides count and width
        run_job(0, 1, 1, 2'd0, 2'd0, 32'h0000_9002, 32'h0000_A001, 16'd9, 1);
        // R12: wrap at both ends
        run_job(1, 0, 0, 2'd0, 2'd1, 32'hFFFF_FFFC, 32'h0000_0004, 16'd3, 1);
        // R7 R10: zero count, pulse with no access
        run_job(1, 0, 1, 2'd0, 2'd0, 32'h0000_1000, 32'h0000_2000, 16'd0, 1);
        // R13: restart while busy is ignored
        run_job(1, 0, 1, 2'd0, 2'd0, 32'h0000_B000, 32'h0000_C000, 16'd6, 0);
        repeat (3) @(posedge clk);
        run_job(0, 0, 0, 2'd1, 2'd1, 32'h0000_D000, 32'h0000_E000, 16'd2, 0);
        while (model_busy || expq.size() != 0) @(negedge clk);
        repeat (3) @(negedge clk);
        chk(expq.size() == 0, "R13 first block intact", 32'(expq.size()), 32'd0);
        // R11: illegal source code, then a legal block keeps err set
        run_job(1, 0, 1, 2'd3, 2'd0, 32'h0000_1000, 32'h0000_2000, 16'd2, 1);
        chk(err == 1'b1, "R11 err set", 32'(err), 32'd1);
        run_job(1, 0, 1, 2'd0, 2'd0, 32'h0000_F000, 32'h0001_0000, 16'd1, 1);
        chk(err == 1'b1, "R11 err sticky", 32'(err), 32'd1);
        report();
    end

endmodule